// File: doc/BRIEF.md
# Byte-wise single-error-correcting memory

This block is a synchronous on-chip byte memory in which every stored byte carries a private 4-bit Hamming check nibble. On a write the byte is encoded into a 12-bit codeword. On a read the codeword is decoded, and any single flipped bit is repaired before the byte reaches the host. The host sees an ordinary byte memory: address, write data, write enable, read enable and read data. No check bits appear at the host port.

No code spans two bytes, so a fault in one location can never spoil a neighbour. Read data is registered. A one-cycle flag reports that a repair took place, and a second flag reports a syndrome that names no codeword position.

A debug port can XOR a 12-bit mask into any stored codeword. Tests use it to plant errors. The address width is a parameter: the full-size instance uses 19 bits, and the default is kept small.

Top module: `byte_sec_mem`

## Requirements
- R1: A write stores the byte as a 12-bit codeword. The codeword has positions 1 to 12, held at bit index position-1. Check bits sit at positions 1, 2, 4 and 8. Data bits 0 to 7 sit at positions 3, 5, 6, 7, 9, 10, 11 and 12 in that order. Each check bit at position 2^k is the even parity of every position whose index has bit k set.
- R2: A read returns its byte on `rd_data` one clock after `rd_en` is sampled high. In cycles that follow no read, `rd_data` holds its previous value.
- R3: The syndrome is the XOR of the indices of all set positions. When it is in the range 1 to 12, the bit at that position is inverted before the data bits are returned, and `fix_flag` is high in the same cycle as that data. A single flip at any of the 12 positions therefore returns the original byte.
- R4: A syndrome of 13, 14 or 15 raises `bad_flag` and returns the stored data bits unrepaired.
- R5: `fix_flag` and `bad_flag` are high only in the cycle after a read, and never both at once. A read of a clean codeword leaves both low.
- R6: With `inj_en` high, the stored codeword at `inj_addr` is XORed with `inj_mask` at the next clock. Repeated injections accumulate, so the same mask applied twice restores the codeword.
- R7: A write re-encodes the location and removes any earlier injected error. When a write and an injection target the same address in the same cycle, the write wins.
- R8: Reset drives `rd_data` to 0 and both flags low. Reset does not clear the array contents.
- R9: An injection at one address leaves every other address unchanged.
- R10: A read and a write to the same address in the same cycle return the value held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the output registers |
| addr | input | ADDR_W | Host address for reads and writes |
| wr_data | input | 8 | Byte to write |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 8 | Registered read byte, repaired when possible |
| fix_flag | output | 1 | The presented byte needed a single-position repair |
| bad_flag | output | 1 | The syndrome pointed outside the codeword |
| inj_en | input | 1 | Debug: apply the injection mask |
| inj_addr | input | ADDR_W | Debug: location to corrupt |
| inj_mask | input | 12 | Debug: XOR mask applied to the stored codeword |

## Verification
The bench flips each of the 12 positions in turn, including the four check positions. A decoder with a wrong position map would return altered data in these cases, or would miss the repair flag when only a check bit is hit.

It also plants chosen double flips whose syndromes land on 13, 14 and 15, and one double flip that aliases to a valid position. A design that repairs blindly, or that zeroes data on a bad syndrome, would return a byte different from the one predicted.

Further cases cover a write racing an injection at the same address, read-before-write in one cycle, injections that cancel out, and a neighbouring location after an injection. A wrong priority or a stale codeword shows up there as a spurious flag or a changed byte.

// File: rtl/byte_sec_mem.sv
module byte_sec_mem #(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wr_data,
  input  logic              wr_en,
  input  logic              rd_en,
  output logic [7:0]        rd_data,
  output logic              fix_flag,
  output logic              bad_flag,
  input  logic              inj_en,
  input  logic [ADDR_W-1:0] inj_addr,
  input  logic [11:0]       inj_mask
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int CW_W  = 12;

  function automatic logic [3:0] syndrome(input logic [CW_W-1:0] cw);
    logic [3:0] s;
    s = '0;
    for (int p = 1; p <= CW_W; p++)
      if (cw[p-1]) s = s ^ 4'(p);
    return s;
  endfunction

  function automatic logic [CW_W-1:0] encode(input logic [7:0] d);
    logic [CW_W-1:0] cw;
    logic [3:0]      s;
    cw = '0;
    cw[2]  = d[0];
    cw[4]  = d[1];
    cw[5]  = d[2];
    cw[6]  = d[3];
    cw[8]  = d[4];
    cw[9]  = d[5];
    cw[10] = d[6];
    cw[11] = d[7];
    s = syndrome(cw);
    cw[0] = s[0];
    cw[1] = s[1];
    cw[3] = s[2];
    cw[7] = s[3];
    return cw;
  endfunction

  logic [CW_W-1:0] mem [DEPTH];
  logic [CW_W-1:0] raw_cw;
  logic [CW_W-1:0] fixed_cw;
  logic [3:0]      syn;
  logic            syn_fix;
  logic            syn_bad;

  always_ff @(posedge clk) begin
    if (inj_en && !(wr_en && inj_addr == addr))
      mem[inj_addr] <= mem[inj_addr] ^ inj_mask;
    if (wr_en)
      mem[addr] <= encode(wr_data);
  end

  assign raw_cw  = mem[addr];
  assign syn     = syndrome(raw_cw);
  assign syn_bad = (syn > 4'd12);
  assign syn_fix = (syn != 4'd0) && !syn_bad;

  always_comb begin
    fixed_cw = raw_cw;
    for (int p = 1; p <= CW_W; p++)
      if (syn_fix && syn == 4'(p)) fixed_cw[p-1] = ~raw_cw[p-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data  <= '0;
      fix_flag <= 1'b0;
      bad_flag <= 1'b0;
    end else begin
      fix_flag <= rd_en && syn_fix;
      bad_flag <= rd_en && syn_bad;
      if (rd_en)
        rd_data <= {fixed_cw[11:8], fixed_cw[6:4], fixed_cw[2]};
    end
  end
endmodule

// File: rtl/byte_sec_mem_chk.sv
module byte_sec_mem_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr,
  input logic [7:0]        wr_data,
  input logic              wr_en,
  input logic              rd_en,
  input logic [7:0]        rd_data,
  input logic              fix_flag,
  input logic              bad_flag,
  input logic              inj_en
);
  // R5
  flags_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(fix_flag && bad_flag));

  // R5
  flags_need_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rd_en) |-> (!fix_flag && !bad_flag));

  // R2
  data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rd_en) |-> $stable(rd_data));

  // R1
  clean_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(wr_en, 2) && !$past(inj_en, 2) && $past(rd_en) && !$past(wr_en) &&
     !$past(inj_en) && $past(addr) == $past(addr, 2))
    |-> (rd_data == $past(wr_data, 2) && !fix_flag && !bad_flag));
endmodule

bind byte_sec_mem byte_sec_mem_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wr_data(wr_data), .wr_en(wr_en),
  .rd_en(rd_en), .rd_data(rd_data), .fix_flag(fix_flag), .bad_flag(bad_flag),
  .inj_en(inj_en)
);

// File: tb/test_byte_sec_mem.sv
module test_byte_sec_mem;
  localparam int AW = 8;
  localparam int NV = 9;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [7:0]    wr_data = '0;
  logic          wr_en = 1'b0;
  logic          rd_en = 1'b0;
  logic [7:0]    rd_data;
  logic          fix_flag;
  logic          bad_flag;
  logic          inj_en = 1'b0;
  logic [AW-1:0] inj_addr = '0;
  logic [11:0]   inj_mask = '0;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  byte_sec_mem #(.ADDR_W(AW)) i_byte_sec_mem (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_data(wr_data), .wr_en(wr_en),
    .rd_en(rd_en), .rd_data(rd_data), .fix_flag(fix_flag), .bad_flag(bad_flag),
    .inj_en(inj_en), .inj_addr(inj_addr), .inj_mask(inj_mask)
  );

  // {addr, data, mask, expected data, expected fix, expected bad}
  localparam logic [37:0] VEC [NV] = '{
    {8'h10, 8'hA5, 12'h000, 8'hA5, 1'b0, 1'b0},
    {8'h11, 8'h00, 12'h004, 8'h00, 1'b1, 1'b0},
    {8'h12, 8'hFF, 12'h800, 8'hFF, 1'b1, 1'b0},
    {8'h13, 8'h3C, 12'h080, 8'h3C, 1'b1, 1'b0},
    {8'h14, 8'h5A, 12'h801, 8'hDA, 1'b0, 1'b1},
    {8'h15, 8'h3C, 12'h108, 8'h2C, 1'b0, 1'b1},
    {8'h16, 8'hFF, 12'h802, 8'h7F, 1'b0, 1'b1},
    {8'h17, 8'h81, 12'h0C0, 8'h89, 1'b0, 1'b1},
    {8'h18, 8'h00, 12'h014, 8'h07, 1'b1, 1'b0}
  };

  task automatic check(input string req, input logic [7:0] ed, input logic ef, input logic eb);
    checks++;
    if (rd_data !== ed || fix_flag !== ef || bad_flag !== eb) begin
      errors++;
      $display("FAIL %s: data=%h fix=%b bad=%b expected data=%h fix=%b bad=%b",
               req, rd_data, fix_flag, bad_flag, ed, ef, eb);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic inject(input logic [AW-1:0] a, input logic [11:0] m);
    @(negedge clk); inj_addr = a; inj_mask = m; inj_en = 1'b1;
    @(negedge clk); inj_en = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a);
    @(negedge clk); addr = a; rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R8 reset state
    check("R8", 8'h00, 1'b0, 1'b0);
    rst_n = 1'b1;

    // R1 R3 R4 table walk
    for (int i = 0; i < NV; i++) begin
      wr(VEC[i][37:30], VEC[i][29:22]);
      if (VEC[i][21:10] != 12'h000) inject(VEC[i][37:30], VEC[i][21:10]);
      rd(VEC[i][37:30]);
      check(VEC[i][1] ? "R3" : (VEC[i][0] ? "R4" : "R1"), VEC[i][9:2], VEC[i][1], VEC[i][0]);
    end

    // R3 every single position
    for (int p = 1; p <= 12; p++) begin
      wr(8'h20, 8'h96);
      inject(8'h20, 12'(1 << (p - 1)));
      rd(8'h20);
      check("R3", 8'h96, 1'b1, 1'b0);
    end

    // R2 hold and latency; R5 flags drop after read
    wr(8'h30, 8'h4E);
    wr(8'h31, 8'hB1);
    rd(8'h30);
    check("R2", 8'h4E, 1'b0, 1'b0);
    @(negedge clk); addr = 8'h31;
    @(negedge clk);
    check("R2", 8'h4E, 1'b0, 1'b0);
    inject(8'h31, 12'h800);
    rd(8'h31);
    check("R3", 8'hB1, 1'b1, 1'b0);
    @(negedge clk);
    check("R5", 8'hB1, 1'b0, 1'b0);

    // R6 accumulating injections cancel
    wr(8'h40, 8'h6D);
    inject(8'h40, 12'h020);
    inject(8'h40, 12'h020);
    rd(8'h40);
    check("R6", 8'h6D, 1'b0, 1'b0);

    // R7 write clears injected error
    inject(8'h40, 12'h801);
    wr(8'h40, 8'h12);
    rd(8'h40);
    check("R7", 8'h12, 1'b0, 1'b0);

    // R7 write wins over same-cycle injection
    @(negedge clk);
    addr = 8'h41; wr_data = 8'hC3; wr_en = 1'b1;
    inj_addr = 8'h41; inj_mask = 12'h801; inj_en = 1'b1;
    @(negedge clk); wr_en = 1'b0; inj_en = 1'b0;
    rd(8'h41);
    check("R7", 8'hC3, 1'b0, 1'b0);

    // R9 neighbour untouched
    wr(8'h50, 8'hE7);
    wr(8'h51, 8'h18);
    inject(8'h50, 12'h801);
    rd(8'h51);
    check("R9", 8'h18, 1'b0, 1'b0);
    rd(8'h50);
    check("R4", 8'h67, 1'b0, 1'b1);

    // R10 read and write same cycle
    wr(8'h60, 8'h33);
    @(negedge clk);
    addr = 8'h60; wr_data = 8'hCC; wr_en = 1'b1; rd_en = 1'b1;
    @(negedge clk); wr_en = 1'b0; rd_en = 1'b0;
    check("R10", 8'h33, 1'b0, 1'b0);
    rd(8'h60);
    check("R10", 8'hCC, 1'b0, 1'b0);

    // R8 reset clears outputs but not contents
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    check("R8", 8'h00, 1'b0, 1'b0);
    rst_n = 1'b1;
    rd(8'h60);
    check("R8", 8'hCC, 1'b0, 1'b0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule